// File: doc/BRIEF.md
# Tick-Based Real-Time Clock with Two Alarms

This block keeps time from a slow crystal clock. A programmable half-period divider turns that clock into a steady tick. Each tick advances a 32-bit counter whose four least significant bits count sixteenths of a second. Two compare registers watch the counter. When the counter reaches a compare value, a sticky flag is raised if that alarm is enabled. A third sticky flag marks every tick. Each flag has its own enable bit, and the interrupt line is high while any enabled flag is set.

Software reaches the block through a small word-addressed register port on the bus clock. Writes and reads each take a one-cycle strobe, and read data appears on the cycle after the strobe. The counter itself lives in the crystal domain. Bus reads of it come from a snapshot that a toggle handshake refreshes once per tick, so a read can never see a half-updated value. A counter write crosses the other way through a request/acknowledge toggle pair. A scratch word survives the soft reset and is cleared only by the power-on reset. This lets software keep a wrap count across a reboot. A clock-select field gates the prescaler. The divider and clock-select values are treated as quasi-static configuration. The bus clock must run at least four times faster than the crystal clock.

Top module: `tick_rtc`

## Requirements
- R1: Divider register at byte offset 0x0C (low 16 bits, reset value = parameter DIV_RESET). With value D, one tick occurs every 2*(D+1) crystal cycles.
- R2: Clock-select register at offset 0x1C (2 bits, reset 0). The prescaler and counter advance only while it holds 3. Any other value holds the counter.
- R3: Counter at offset 0x00. It increments by exactly one per tick and wraps from 0xFFFFFFFF to 0. Reads return a per-tick snapshot, so successive reads differ by 0 or 1 except across a software write.
- R4: A write to offset 0x00 loads the counter through a handshake, and later reads return the written value. Any further counter write made while a load is still in flight is dropped.
- R5: Alarm compare registers sit at 0x04 (alarm 0) and 0x18 (alarm 1), both reset to 0. On the tick where the counter becomes equal to an alarm value, that alarm's flag (status bit 0 or bit 4) is set, but only if its enable (bit 2 or bit 6) is 1. A counter load does not set a flag.
- R6: Status bit 1 is set on every tick. Status bit 3 is its enable.
- R7: Status is at 0x08. Writing 1 to flag bits 0, 1 or 4 clears that flag, and writing 0 leaves it unchanged. Enable bits 2, 3 and 6 are plain read/write. A flag event in the same cycle as its clear keeps the flag set.
- R8: irq is high while any flag is set together with its enable. It stays high until software clears the flag or its enable.
- R9: Scratch word at 0x40 is 32 bits. It is reset only by por_n and keeps its value through rst_n.
- R10: Reads from any other offset return 0, and writes to them change no register.
- R11: After rst_n every register except the divider and the scratch word reads 0, irq is low, and reg_rdata holds the selected register on the cycle after reg_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| xtal_clk | input | 1 | Crystal clock feeding the prescaler |
| rst_n | input | 1 | Soft reset for both domains, active low |
| por_n | input | 1 | Power-on reset for the scratch word, active low |
| reg_addr | input | 7 | Byte offset of the accessed register |
| reg_wr | input | 1 | One-cycle write strobe |
| reg_rd | input | 1 | One-cycle read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| irq | output | 1 | Level interrupt from enabled flags |

## Verification
The bench builds the block with DIV_RESET = 2 and drives an 80 ns crystal clock against the 10 ns bus clock. A tick then arrives every 48 bus cycles, or every 32 after the divider is rewritten to 1, and these periods can be measured exactly from the bus side. Because ticks come this quickly, the bench can load the counter near 0xFFFFFFFF to see the wrap, and can walk the counter onto both alarm values within a few thousand cycles.

// File: rtl/tick_rtc_pkg.sv
package tick_rtc_pkg;
  localparam int ADDR_W = 7;

  localparam logic [ADDR_W-1:0] OFF_COUNT = 7'h00;
  localparam logic [ADDR_W-1:0] OFF_ALM0  = 7'h04;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 7'h08;
  localparam logic [ADDR_W-1:0] OFF_DIV   = 7'h0C;
  localparam logic [ADDR_W-1:0] OFF_ALM1  = 7'h18;
  localparam logic [ADDR_W-1:0] OFF_CSEL  = 7'h1C;
  localparam logic [ADDR_W-1:0] OFF_SCR   = 7'h40;

  localparam int N_ALARM = 2;
  localparam logic [1:0] CSEL_XTAL = 2'd3;

  // status word bit positions
  localparam int ST_AF0 = 0;
  localparam int ST_TF  = 1;
  localparam int ST_AE0 = 2;
  localparam int ST_TE  = 3;
  localparam int ST_AF1 = 4;
  localparam int ST_AE1 = 6;

  function automatic logic [ADDR_W-1:0] alarm_off(input int idx);
    return (idx == 0) ? OFF_ALM0 : OFF_ALM1;
  endfunction

  function automatic int alarm_flag_bit(input int idx);
    return (idx == 0) ? ST_AF0 : ST_AF1;
  endfunction

  function automatic int alarm_en_bit(input int idx);
    return (idx == 0) ? ST_AE0 : ST_AE1;
  endfunction

  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    return (a == OFF_COUNT) || (a == OFF_ALM0) || (a == OFF_STAT) || (a == OFF_DIV) ||
           (a == OFF_ALM1) || (a == OFF_CSEL) || (a == OFF_SCR);
  endfunction
endpackage

// File: rtl/tick_rtc_sync.sv
module tick_rtc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tick_rtc_prescaler.sv
module tick_rtc_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] phase_cnt;
  logic             half;
  logic             wrap;

  assign wrap = (phase_cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_cnt <= '0;
      half      <= 1'b0;
    end else if (!run) begin
      phase_cnt <= '0;
      half      <= 1'b0;
    end else if (wrap) begin
      phase_cnt <= '0;
      half      <= ~half;
    end else begin
      phase_cnt <= phase_cnt + DIV_W'(1);
    end
  end

  // one tick per full output period: at the end of the second half
  assign tick = run && half && wrap;

  assert_idle_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick);
endmodule

// File: rtl/tick_rtc_counter.sv
module tick_rtc_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ld_req,
  input  logic [W-1:0] ld_data,
  output logic [W-1:0] cnt,
  output logic         pub_tgl,
  output logic         ld_ack
);
  logic load_now;
  assign load_now = (ld_req != ld_ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pub_tgl <= 1'b0;
      ld_ack  <= 1'b0;
    end else if (load_now) begin
      cnt    <= ld_data;
      ld_ack <= ld_req;
    end else if (tick) begin
      cnt     <= cnt + W'(1);
      pub_tgl <= ~pub_tgl;
    end
  end

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_now) |=> (cnt == $past(cnt) + W'(1)));
  assert_load_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> (cnt == $past(ld_data)));
endmodule

// File: rtl/tick_rtc_alarm.sv
module tick_rtc_alarm #(
  parameter int W        = 32,
  parameter int FLAG_BIT = 0,
  parameter int EN_BIT   = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_val,
  input  logic         wr_stat,
  input  logic [W-1:0] wdata,
  input  logic         cmp_evt,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] value,
  output logic         en,
  output logic         flag
);
  logic hit;
  assign hit = cmp_evt && en && (cnt == value);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
      en    <= 1'b0;
      flag  <= 1'b0;
    end else begin
      if (wr_val)  value <= wdata;
      if (wr_stat) en    <= wdata[EN_BIT];
      if (hit)                              flag <= 1'b1;
      else if (wr_stat && wdata[FLAG_BIT])  flag <= 1'b0;
    end
  end

  assert_alarm_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !$past(flag)) |-> $past(en));
  assert_zero_keeps_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && wr_stat && !wdata[FLAG_BIT]) |=> flag);
endmodule

// File: rtl/tick_rtc.sv
module tick_rtc
  import tick_rtc_pkg::*;
#(
  parameter int W           = 32,
  parameter int DIV_W       = 16,
  parameter int CSEL_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_RESET   = 1023
) (
  input  logic              bus_clk,
  input  logic              xtal_clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  output logic              irq
);
  // bus-domain registers
  logic [DIV_W-1:0]  div_q;
  logic [CSEL_W-1:0] csel_q;
  logic              tick_en, tick_flag;
  logic [W-1:0]      scratch_q, snap_q, held_q;
  logic              req_tgl, pub_seen, ack_seen;
  logic [W-1:0]      stat_w;

  // crossings
  logic         run_bus, run_x, req_x, pub_x, ack_x, pub_s, ack_s, tick_x;
  logic [W-1:0] cnt_x;

  logic [N_ALARM-1:0] alm_en, alm_flag;
  logic [W-1:0]       alm_val [N_ALARM];

  logic wr_cnt, wr_stat, pub_evt, ack_evt, pending;

  assign wr_cnt  = reg_wr && (reg_addr == OFF_COUNT);
  assign wr_stat = reg_wr && (reg_addr == OFF_STAT);
  assign pub_evt = (pub_s != pub_seen);
  assign ack_evt = (ack_s != ack_seen);
  assign pending = (req_tgl != ack_seen);
  assign run_bus = (csel_q == CSEL_W'(CSEL_XTAL));

  tick_rtc_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
    .clk(xtal_clk), .rst_n(rst_n), .d(run_bus), .q(run_x));
  tick_rtc_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(xtal_clk), .rst_n(rst_n), .d(req_tgl), .q(req_x));
  tick_rtc_sync #(.STAGES(SYNC_STAGES)) u_pub_sync (
    .clk(bus_clk), .rst_n(rst_n), .d(pub_x), .q(pub_s));
  tick_rtc_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(bus_clk), .rst_n(rst_n), .d(ack_x), .q(ack_s));

  tick_rtc_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(xtal_clk), .rst_n(rst_n), .run(run_x), .div(div_q), .tick(tick_x));

  tick_rtc_counter #(.W(W)) u_cnt (
    .clk(xtal_clk), .rst_n(rst_n), .tick(tick_x), .ld_req(req_x),
    .ld_data(held_q), .cnt(cnt_x), .pub_tgl(pub_x), .ld_ack(ack_x));

  for (genvar g = 0; g < N_ALARM; g++) begin : g_alarm
    tick_rtc_alarm #(
      .W(W), .FLAG_BIT(alarm_flag_bit(g)), .EN_BIT(alarm_en_bit(g))
    ) u_alm (
      .clk(bus_clk), .rst_n(rst_n),
      .wr_val(reg_wr && (reg_addr == alarm_off(g))),
      .wr_stat(wr_stat), .wdata(reg_wdata),
      .cmp_evt(pub_evt), .cnt(cnt_x),
      .value(alm_val[g]), .en(alm_en[g]), .flag(alm_flag[g]));
  end

  // snapshot and load handshake
  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      pub_seen <= 1'b0;
      ack_seen <= 1'b0;
      snap_q   <= '0;
      held_q   <= '0;
      req_tgl  <= 1'b0;
    end else begin
      pub_seen <= pub_s;
      ack_seen <= ack_s;
      if (pub_evt)      snap_q <= cnt_x;
      else if (ack_evt) snap_q <= held_q;
      if (wr_cnt && !pending) begin
        held_q  <= reg_wdata;
        req_tgl <= ~req_tgl;
      end
    end
  end

  // configuration and tick flag
  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q     <= DIV_W'(DIV_RESET);
      csel_q    <= '0;
      tick_en   <= 1'b0;
      tick_flag <= 1'b0;
    end else begin
      if (reg_wr && (reg_addr == OFF_DIV))  div_q  <= reg_wdata[DIV_W-1:0];
      if (reg_wr && (reg_addr == OFF_CSEL)) csel_q <= reg_wdata[CSEL_W-1:0];
      if (wr_stat) tick_en <= reg_wdata[ST_TE];
      if (pub_evt)                         tick_flag <= 1'b1;
      else if (wr_stat && reg_wdata[ST_TF]) tick_flag <= 1'b0;
    end
  end

  // scratch word follows the power-on reset only
  always_ff @(posedge bus_clk or negedge por_n) begin
    if (!por_n) scratch_q <= '0;
    else if (reg_wr && (reg_addr == OFF_SCR)) scratch_q <= reg_wdata;
  end

  always_comb begin
    stat_w         = '0;
    stat_w[ST_AF0] = alm_flag[0];
    stat_w[ST_TF]  = tick_flag;
    stat_w[ST_AE0] = alm_en[0];
    stat_w[ST_TE]  = tick_en;
    stat_w[ST_AF1] = alm_flag[1];
    stat_w[ST_AE1] = alm_en[1];
  end

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        OFF_COUNT: reg_rdata <= snap_q;
        OFF_ALM0:  reg_rdata <= alm_val[0];
        OFF_STAT:  reg_rdata <= stat_w;
        OFF_DIV:   reg_rdata <= W'(div_q);
        OFF_ALM1:  reg_rdata <= alm_val[1];
        OFF_CSEL:  reg_rdata <= W'(csel_q);
        OFF_SCR:   reg_rdata <= scratch_q;
        default:   reg_rdata <= '0;
      endcase
    end
  end

  assign irq = (|(alm_flag & alm_en)) || (tick_flag && tick_en);

  assert_busy_write_dropped_R4: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr_cnt && pending) |=> ($stable(held_q) && $stable(req_tgl)));
  assert_snap_quiet_R3: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (!pub_evt && !ack_evt) |=> $stable(snap_q));
  assert_unmapped_zero_R10: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (reg_rd && !is_mapped(reg_addr)) |=> (reg_rdata == '0));
  assert_irq_hold_R8: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (irq && !wr_stat) |=> irq);
endmodule

// File: tb/sim_tick_rtc.sv
module sim_tick_rtc;
  localparam int DIVR = 2;

  logic        bus_clk = 1'b0;
  logic        xtal_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por_n = 1'b0;
  logic [6:0]  addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 bus_clk = ~bus_clk;
  initial begin
    #3;
    forever #40 xtal_clk = ~xtal_clk;
  end

  tick_rtc #(.DIV_RESET(DIVR)) u0 (
    .bus_clk(bus_clk), .xtal_clk(xtal_clk), .rst_n(rst_n), .por_n(por_n),
    .reg_addr(addr), .reg_wr(wr), .reg_rd(rd), .reg_wdata(wdata),
    .reg_rdata(rdata), .irq(irq));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge bus_clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge bus_clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge bus_clk);
    addr = a; rd = 1'b1;
    @(negedge bus_clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic wait_cnt(input logic [31:0] target, output bit hit);
    logic [31:0] v;
    hit = 1'b0;
    for (int i = 0; i < 3000 && !hit; i++) begin
      bus_rd(7'h00, v);
      if (v == target) hit = 1'b1;
    end
  endtask

  task automatic next_change(input logic [31:0] prev, output logic [31:0] v);
    v = prev;
    for (int i = 0; i < 1000 && v == prev; i++) bus_rd(7'h00, v);
  endtask

  task automatic measure(input int exp, input string req);
    logic [31:0] prev;
    int last = 0;
    int n = 0;
    int cyc = 0;
    @(negedge bus_clk);
    addr = 7'h00; rd = 1'b1;
    @(negedge bus_clk);
    prev = rdata;
    while (n < 4 && cyc < 2000) begin
      @(negedge bus_clk);
      cyc++;
      if (rdata != prev) begin
        if (n >= 2) chk(cyc - last == exp, req, 32'(cyc - last), 32'(exp));
        chk(rdata == prev + 32'd1, "R3 step", rdata, prev + 32'd1);
        last = cyc; prev = rdata; n++;
      end
    end
    rd = 1'b0;
    chk(n == 4, req, 32'(n), 32'd4);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    bus_rd(7'h00, v); chk(v == 0, "R11 counter", v, 0);
    bus_rd(7'h04, v); chk(v == 0, "R5 alarm0 reset", v, 0);
    bus_rd(7'h18, v); chk(v == 0, "R5 alarm1 reset", v, 0);
    bus_rd(7'h08, v); chk(v == 0, "R11 status", v, 0);
    bus_rd(7'h0C, v); chk(v == DIVR, "R1 divider reset", v, DIVR);
    bus_rd(7'h1C, v); chk(v == 0, "R2 clock-select reset", v, 0);
    bus_rd(7'h40, v); chk(v == 0, "R9 scratch reset", v, 0);
    chk(irq == 1'b0, "R11 irq", 32'(irq), 0);
    repeat (400) @(negedge bus_clk);
    bus_rd(7'h00, v); chk(v == 0, "R2 held without select", v, 0);
  endtask

  task automatic t_period;
    bus_wr(7'h1C, 32'h3);
    measure(2 * (DIVR + 1) * 8, "R1 period div=2");
    bus_wr(7'h0C, 32'h1);
    measure(2 * 2 * 8, "R1 period div=1");
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    bit hit;
    bus_wr(7'h00, 32'hFFFF_FFFE);
    wait_cnt(32'hFFFF_FFFE, hit);
    chk(hit, "R4 load seen", 32'(hit), 1);
    next_change(32'hFFFF_FFFE, v); chk(v == 32'hFFFF_FFFF, "R3 before wrap", v, 32'hFFFF_FFFF);
    next_change(32'hFFFF_FFFF, v); chk(v == 32'h0, "R3 wrap", v, 0);
  endtask

  task automatic t_busy;
    logic [31:0] v;
    bus_wr(7'h00, 32'h100);
    bus_wr(7'h00, 32'h5000);
    repeat (150) @(negedge bus_clk);
    bus_rd(7'h00, v);
    chk(v >= 32'h100 && v <= 32'h106, "R4 second write dropped", v, 32'h100);
  endtask

  task automatic t_alarm0;
    logic [31:0] v;
    bit hit;
    bus_wr(7'h04, 32'h14);
    bus_wr(7'h08, 32'h4);
    bus_wr(7'h00, 32'h10);
    wait_cnt(32'h10, hit);
    chk(irq == 1'b0, "R8 no irq before alarm", 32'(irq), 0);
    wait_cnt(32'h14, hit);
    repeat (3) @(negedge bus_clk);
    bus_rd(7'h08, v); chk(v[0] == 1'b1, "R5 alarm0 flag", v, 32'h5);
    chk(irq == 1'b1, "R8 irq on alarm0", 32'(irq), 1);
    wait_cnt(32'h16, hit);
    bus_rd(7'h08, v); chk(v[0] == 1'b1, "R7 flag sticky", v, 32'h5);
    bus_wr(7'h08, 32'h5);
    bus_rd(7'h08, v); chk(v[0] == 1'b0 && v[2] == 1'b1, "R7 clear by one", v, 32'h4);
    chk(irq == 1'b0, "R8 irq drops", 32'(irq), 0);
  endtask

  task automatic t_alarm1;
    logic [31:0] v;
    bit hit;
    bus_wr(7'h18, 32'h30);
    bus_wr(7'h08, 32'h0);
    bus_wr(7'h00, 32'h2E);
    wait_cnt(32'h31, hit);
    bus_rd(7'h08, v); chk(v[4] == 1'b0, "R5 disabled alarm1 silent", v, 0);
    chk(irq == 1'b0, "R8 no irq when disabled", 32'(irq), 0);
    bus_wr(7'h08, 32'h40);
    bus_wr(7'h00, 32'h2E);
    wait_cnt(32'h2E, hit);
    wait_cnt(32'h30, hit);
    repeat (3) @(negedge bus_clk);
    bus_rd(7'h08, v); chk(v[4] == 1'b1, "R5 alarm1 flag", v, 32'h50);
    chk(irq == 1'b1, "R8 irq on alarm1", 32'(irq), 1);
    bus_wr(7'h08, 32'h40);
    bus_rd(7'h08, v); chk(v[4] == 1'b1, "R7 zero leaves flag", v, 32'h50);
    bus_wr(7'h08, 32'h50);
    bus_rd(7'h08, v); chk(v[4] == 1'b0 && v[6] == 1'b1, "R7 alarm1 cleared", v, 32'h40);
    chk(irq == 1'b0, "R8 irq low after clear", 32'(irq), 0);
  endtask

  task automatic t_tick;
    logic [31:0] v, s;
    bus_wr(7'h08, 32'h2);
    bus_rd(7'h00, v);
    next_change(v, v);
    bus_rd(7'h08, s); chk(s[1] == 1'b1, "R6 tick flag", s, 32'h2);
    chk(irq == 1'b0, "R6 tick masked", 32'(irq), 0);
    bus_wr(7'h08, 32'h8);
    chk(irq == 1'b1, "R8 tick irq enabled", 32'(irq), 1);
    next_change(v, v);
    bus_wr(7'h08, 32'hA);
    chk(irq == 1'b0, "R7 tick flag cleared", 32'(irq), 0);
    bus_rd(7'h08, s); chk(s[1] == 1'b0 && s[3] == 1'b1, "R7 tick status", s, 32'h8);
    next_change(v, v);
    chk(irq == 1'b1, "R6 next tick raises", 32'(irq), 1);
    bus_wr(7'h08, 32'h2);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    bus_wr(7'h10, 32'hFFFF_FFFF);
    bus_wr(7'h44, 32'hFFFF_FFFF);
    bus_wr(7'h0A, 32'hFFFF_FFFF);
    bus_rd(7'h10, v); chk(v == 0, "R10 read 0x10", v, 0);
    bus_rd(7'h44, v); chk(v == 0, "R10 read 0x44", v, 0);
    bus_rd(7'h0A, v); chk(v == 0, "R10 read 0x0A", v, 0);
    bus_rd(7'h04, v); chk(v == 32'h14, "R10 alarm0 untouched", v, 32'h14);
    bus_rd(7'h18, v); chk(v == 32'h30, "R10 alarm1 untouched", v, 32'h30);
    bus_rd(7'h0C, v); chk(v == 32'h1, "R10 divider untouched", v, 1);
    bus_rd(7'h40, v); chk(v == 0, "R10 scratch untouched", v, 0);
  endtask

  task automatic t_stop;
    logic [31:0] a, b;
    bus_wr(7'h1C, 32'h2);
    repeat (60) @(negedge bus_clk);
    bus_rd(7'h00, a);
    repeat (300) @(negedge bus_clk);
    bus_rd(7'h00, b);
    chk(a == b, "R2 stopped by clock-select", b, a);
  endtask

  task automatic t_scratch;
    logic [31:0] v;
    bus_wr(7'h40, 32'hC0FF_EE11);
    bus_rd(7'h40, v); chk(v == 32'hC0FF_EE11, "R9 scratch write", v, 32'hC0FF_EE11);
    @(negedge bus_clk); rst_n = 1'b0;
    repeat (20) @(negedge bus_clk); rst_n = 1'b1;
    bus_rd(7'h40, v); chk(v == 32'hC0FF_EE11, "R9 survives soft reset", v, 32'hC0FF_EE11);
    bus_rd(7'h04, v); chk(v == 0, "R11 alarm0 after soft reset", v, 0);
    bus_rd(7'h0C, v); chk(v == DIVR, "R11 divider after soft reset", v, DIVR);
    @(negedge bus_clk); por_n = 1'b0;
    repeat (2) @(negedge bus_clk); por_n = 1'b1;
    bus_rd(7'h40, v); chk(v == 0, "R9 cleared by power-on", v, 0);
  endtask

  initial begin
    repeat (150000) @(posedge bus_clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20) @(negedge bus_clk);
    rst_n = 1'b1; por_n = 1'b1;
    t_reset();
    t_period();
    t_wrap();
    t_busy();
    t_alarm0();
    t_alarm1();
    t_tick();
    t_unmapped();
    t_stop();
    t_scratch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule